// File: doc/BRIEF.md
# Boot-Block Flash Command Interface

This block is a behavioural model of the command side of a boot-block NOR flash on a 32-bit bus. The bus is two 16-bit devices placed side by side, so a command word carries the same command byte in the low byte of each 16-bit half. A host writes command words and data words. It reads back array contents, identifier codes or a status byte, depending on the read mode set by the last command.

Program and erase are carried out by an internal write engine. The engine stays busy for a number of clock cycles set by a parameter. While it runs, the host polls the ready bit in the status byte. The array is a small register memory. At the bottom of the address range are eight small parameter blocks. Above them are main blocks, each eight times the size of a parameter block. Erase always clears a whole block to ones.

Top module: `bootflash_cmd`

## Requirements
- R1: After reset the read mode is array, every array word reads 0xFFFFFFFF, and the status byte shows ready with no error bits set.
- R2: A write while the engine is idle counts as a command only when it has the form {8'h00, c, 8'h00, c}. The recognised values of c are 0xFF (array mode), 0x90 (identifier mode), 0x70 (status mode), 0x50 (clear errors), 0x40 (program setup) and 0x20 (erase setup). Any other idle write, including a lone 0xD0, changes nothing.
- R3: In identifier mode, word address 0 reads 0x00890089, word address 1 reads 0x88F488F4, and every other address reads 0.
- R4: In status mode the read data is {8'h00, s, 8'h00, s}. In s, bit 7 is ready (it reads 0 while busy), bit 5 is the erase error, bit 4 is the program error, and all other bits are 0.
- R5: A program-setup command followed by a data word starts a program of that word at the data word's address. The ready bit then reads 0 for exactly PROG_CYC cycles, after which the word holds old AND data.
- R6: If the programmed data has a 1 where the old word has a 0, the program-error bit is set. The stored word is still old AND data.
- R7: An erase-setup command followed by the confirm word {8'h00, 8'hD0, 8'h00, 8'hD0} sets every word of the block that holds the confirm address to ones. Blocks of other words are untouched. Parameter blocks are PBLK_WORDS words each, and main blocks are 8*PBLK_WORDS words each, above the parameter region.
- R8: If an erase setup is followed by any word other than the confirm, both error bits are set, no array word changes, and the word has no other effect.
- R9: The error bits are sticky. Only the clear command (c = 0x50) resets them.
- R10: Program setup and erase setup switch the read mode to status. The mode stays status through the operation and after it, until a later array or identifier command. Writes made while the engine is busy are ignored.
- R11: After an erase confirm, the ready bit reads 0 for exactly ERASE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | AW (7) | Word address for reads and writes |
| bus_wdata | input | 32 | Write data or command word |
| bus_rdata | output | 32 | Read data chosen by the current read mode |

## Verification
The checker makes three assumptions about the host. It holds bus_we low during reset. It uses each write strobe for exactly one word. It leaves error recovery to the clear command, so that any drop in an error bit can be traced to a clear word written one cycle earlier. The stimulus follows these rules: it writes one word per cycle, it starts every program or erase from the idle state, and it deliberately breaks one erase sequence and writes during busy windows, so that the ignore and error paths run while the assertions stay valid.

// File: rtl/bootflash_cmd.sv
module bootflash_cmd #(
  parameter int PBLK_WORDS = 4,
  parameter int MAIN_BLKS  = 3,
  parameter int PROG_CYC   = 5,
  parameter int ERASE_CYC  = 12,
  parameter int AW = $clog2(8 * PBLK_WORDS + MAIN_BLKS * 8 * PBLK_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata
);
  localparam int PARAM_SPAN = 8 * PBLK_WORDS;
  localparam int MAIN_WORDS = 8 * PBLK_WORDS;
  localparam int WORDS = PARAM_SPAN + MAIN_BLKS * MAIN_WORDS;

  localparam logic [1:0] M_ARRAY = 2'd0, M_IDENT = 2'd1, M_STATUS = 2'd2;
  localparam logic [1:0] S_IDLE = 2'd0, S_PGM = 2'd1, S_ERS = 2'd2, S_BUSY = 2'd3;

  logic [31:0]   mem [WORDS];
  logic [1:0]    mode, state, errs;
  logic [AW-1:0] op_addr;
  logic [31:0]   op_data, cnt;
  logic          op_erase, busy;
  logic [7:0]    cmd, st;
  logic          cmd_ok;
  int            blk_lo, blk_sz;

  assign busy   = state == S_BUSY;
  assign cmd    = bus_wdata[7:0];
  assign cmd_ok = bus_wdata == {8'h00, cmd, 8'h00, cmd};
  assign st     = {~busy, 1'b0, errs, 4'b0000};

  always_comb begin
    if (int'(op_addr) < PARAM_SPAN) begin
      blk_lo = (int'(op_addr) / PBLK_WORDS) * PBLK_WORDS;
      blk_sz = PBLK_WORDS;
    end else begin
      blk_lo = PARAM_SPAN + ((int'(op_addr) - PARAM_SPAN) / MAIN_WORDS) * MAIN_WORDS;
      blk_sz = MAIN_WORDS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= M_ARRAY;
      state    <= S_IDLE;
      errs     <= 2'b00;
      cnt      <= '0;
      op_addr  <= '0;
      op_data  <= '0;
      op_erase <= 1'b0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      case (state)
        S_IDLE: if (bus_we && cmd_ok) begin
          case (cmd)
            8'hFF: mode <= M_ARRAY;
            8'h90: mode <= M_IDENT;
            8'h70: mode <= M_STATUS;
            8'h50: errs <= 2'b00;
            8'h40: begin state <= S_PGM; mode <= M_STATUS; end
            8'h20: begin state <= S_ERS; mode <= M_STATUS; end
            default: ;
          endcase
        end
        S_PGM: if (bus_we) begin
          op_addr  <= bus_addr;
          op_data  <= bus_wdata;
          op_erase <= 1'b0;
          cnt      <= 32'(PROG_CYC);
          state    <= S_BUSY;
        end
        S_ERS: if (bus_we) begin
          if (cmd_ok && cmd == 8'hD0) begin
            op_addr  <= bus_addr;
            op_erase <= 1'b1;
            cnt      <= 32'(ERASE_CYC);
            state    <= S_BUSY;
          end else begin
            errs  <= 2'b11;
            state <= S_IDLE;
          end
        end
        default: begin
          if (cnt == 32'd1) begin
            state <= S_IDLE;
            if (op_erase) begin
              for (int i = 0; i < WORDS; i++)
                if (i >= blk_lo && i < blk_lo + blk_sz) mem[i] <= '1;
            end else begin
              mem[op_addr] <= mem[op_addr] & op_data;
              if (|(~mem[op_addr] & op_data)) errs[0] <= 1'b1;
            end
          end else begin
            cnt <= cnt - 32'd1;
          end
        end
      endcase
    end
  end

  always_comb begin
    case (mode)
      M_ARRAY: bus_rdata = mem[bus_addr];
      M_IDENT: bus_rdata = (bus_addr == '0) ? 32'h0089_0089 :
                           (bus_addr == AW'(1)) ? 32'h88F4_88F4 : 32'h0;
      default: bus_rdata = {8'h00, st, 8'h00, st};
    endcase
  end
endmodule

module bootflash_cmd_chk #(
  parameter int PROG_CYC  = 5,
  parameter int ERASE_CYC = 12,
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          busy,
  input logic [1:0]    mode,
  input logic [1:0]    errs
);
  int run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= 0;
    else run <= busy ? run + 1 : 0;
  end

  // R10
  busy_in_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mode == 2'd2);

  // R4
  busy_reads_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bus_rdata[7] == 1'b0 && bus_rdata[23] == 1'b0));

  // R9
  errs_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(errs) & ~errs)) |-> $past(bus_we && bus_wdata == 32'h0050_0050));

  // R3
  ident_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && bus_addr == '0) |-> bus_rdata == 32'h0089_0089);

  // R5
  // R11
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == PROG_CYC || run == ERASE_CYC));

  // R10
  stays_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> mode == 2'd2);
endmodule

bind bootflash_cmd bootflash_cmd_chk #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .mode(mode), .errs(errs)
);

// File: tb/bootflash_cmd_bench.sv
module bootflash_cmd_bench;
  localparam int PW = 4, MB = 3, PC = 5, EC = 12;
  localparam int PS = 8 * PW, MW = 8 * PW, WORDS = PS + MB * MW, AW = $clog2(WORDS);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, we;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  wire  [31:0]   rdata;

  bootflash_cmd #(.PBLK_WORDS(PW), .MAIN_BLKS(MB), .PROG_CYC(PC), .ERASE_CYC(EC)) u_bootflash_cmd (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata));

  int errors = 0, checks = 0;
  string req = "R1";

  logic [31:0] mm [WORDS];
  int m_mode, m_phase, m_left, m_addr;
  logic [31:0] m_data;
  bit m_erase, e_ers, e_pgm;

  task automatic m_reset();
    for (int i = 0; i < WORDS; i++) mm[i] = 32'hFFFF_FFFF;
    m_mode = 0; m_phase = 0; m_left = 0; m_addr = 0; m_data = 0;
    m_erase = 0; e_ers = 0; e_pgm = 0;
  endtask

  function automatic logic [31:0] m_read(int a);
    logic [7:0] s;
    if (m_mode == 0) return mm[a];
    if (m_mode == 1) return (a == 0) ? 32'h0089_0089 : (a == 1) ? 32'h88F4_88F4 : 32'h0;
    s = {(m_phase != 3), 1'b0, e_ers, e_pgm, 4'h0};
    return {8'h00, s, 8'h00, s};
  endfunction

  task automatic m_step(bit w, int a, logic [31:0] d);
    logic [31:0] old;
    int base, len;
    bit is_cmd;
    is_cmd = (d == {8'h00, d[7:0], 8'h00, d[7:0]});
    if (m_phase == 3) begin
      if (m_left == 1) begin
        m_phase = 0;
        if (m_erase) begin
          if (m_addr < PS) begin base = (m_addr / PW) * PW; len = PW; end
          else begin base = PS + ((m_addr - PS) / MW) * MW; len = MW; end
          for (int i = base; i < base + len; i++) mm[i] = 32'hFFFF_FFFF;
        end else begin
          old = mm[m_addr];
          mm[m_addr] = old & m_data;
          if ((~old & m_data) != 0) e_pgm = 1;
        end
      end else m_left--;
    end else if (w && m_phase == 1) begin
      m_addr = a; m_data = d; m_erase = 0; m_left = PC; m_phase = 3;
    end else if (w && m_phase == 2) begin
      if (d == 32'h00D0_00D0) begin m_addr = a; m_erase = 1; m_left = EC; m_phase = 3; end
      else begin e_ers = 1; e_pgm = 1; m_phase = 0; end
    end else if (w && is_cmd) begin
      case (d[7:0])
        8'hFF: m_mode = 0;
        8'h90: m_mode = 1;
        8'h70: m_mode = 2;
        8'h50: begin e_ers = 0; e_pgm = 0; end
        8'h40: begin m_phase = 1; m_mode = 2; end
        8'h20: begin m_phase = 2; m_mode = 2; end
        default: ;
      endcase
    end
  endtask

  task automatic check(logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit w, int a, logic [31:0] d);
    @(negedge clk);
    we = w; addr = AW'(a); wdata = d;
    #1 check(rdata, m_read(a), "model");
    @(posedge clk);
    #1 m_step(w, a, d);
  endtask

  task automatic wr(int a, logic [31:0] d); cyc(1'b1, a, d); endtask

  task automatic peek(int a, logic [31:0] v, string r);
    req = r;
    @(negedge clk);
    we = 1'b0; addr = AW'(a); wdata = '0;
    #1 check(rdata, v, "literal");
    check(rdata, m_read(a), "model");
    @(posedge clk);
    #1 m_step(1'b0, a, '0);
  endtask

  task automatic count_busy(int expect_n, string r);
    int n = 0;
    bit rdy;
    req = r;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      we = 1'b0; addr = '0; wdata = '0;
      #1 check(rdata, m_read(0), "model");
      rdy = rdata[7];
      if (!rdy) n++;
      @(posedge clk);
      #1 m_step(1'b0, 0, '0);
      if (rdy) break;
    end
    check(32'(n), 32'(expect_n), "busy cycles");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    peek(0, 32'hFFFF_FFFF, "R1");
    peek(WORDS - 1, 32'hFFFF_FFFF, "R1");
    req = "R1"; wr(0, 32'h0070_0070);
    peek(9, 32'h0080_0080, "R1");

    // R3: identifier codes
    req = "R3"; wr(0, 32'h0090_0090);
    peek(0, 32'h0089_0089, "R3");
    peek(1, 32'h88F4_88F4, "R3");
    peek(2, 32'h0, "R3");

    // R5: program, then read back
    req = "R5"; wr(0, 32'h00FF_00FF);
    wr(3, 32'h0040_0040);
    wr(3, 32'h1234_5678);
    peek(3, 32'h0000_0000, "R4");
    count_busy(PC - 1, "R5");
    peek(3, 32'h0080_0080, "R10");
    req = "R5"; wr(0, 32'h00FF_00FF);
    peek(3, 32'h1234_5678, "R5");

    // R6: program that needs 0->1
    req = "R6"; wr(3, 32'h0040_0040);
    wr(3, 32'hFFFF_0000);
    count_busy(PC, "R6");
    peek(3, 32'h0090_0090, "R6");
    req = "R6"; wr(0, 32'h00FF_00FF);
    peek(3, 32'h1234_0000, "R6");
    req = "R9"; wr(0, 32'h0050_0050);

    // setup words for erase tests
    req = "R7";
    wr(4, 32'h0040_0040);  wr(4, 32'hA5A5_A5A5);  count_busy(PC, "R5");
    wr(40, 32'h0040_0040); wr(40, 32'h0F0F_0F0F); count_busy(PC, "R5");
    wr(70, 32'h0040_0040); wr(70, 32'h3C3C_3C3C); count_busy(PC, "R5");

    // R2: malformed and lone confirm words are ignored
    req = "R2"; wr(0, 32'h00FF_00FF);
    wr(4, 32'h0070_0071);
    wr(4, 32'h7070_7070);
    wr(4, 32'h00D0_00D0);
    peek(4, 32'hA5A5_A5A5, "R2");

    // R7 / R11: parameter block erase
    req = "R7"; wr(1, 32'h0020_0020);
    wr(2, 32'h00D0_00D0);
    count_busy(EC, "R11");
    req = "R7"; wr(0, 32'h00FF_00FF);
    peek(3, 32'hFFFF_FFFF, "R7");
    peek(4, 32'hA5A5_A5A5, "R7");

    // R7: main block erase
    req = "R7"; wr(50, 32'h0020_0020);
    wr(63, 32'h00D0_00D0);
    count_busy(EC, "R11");
    req = "R7"; wr(0, 32'h00FF_00FF);
    peek(40, 32'hFFFF_FFFF, "R7");
    peek(70, 32'h3C3C_3C3C, "R7");

    // R8: broken erase sequence
    req = "R8"; wr(4, 32'h0020_0020);
    wr(4, 32'h00FF_00FF);
    peek(4, 32'h00B0_00B0, "R8");

    // R9: errors survive other commands
    req = "R9"; wr(0, 32'h0090_0090);
    wr(0, 32'h0070_0070);
    peek(4, 32'h00B0_00B0, "R9");
    req = "R8"; wr(0, 32'h00FF_00FF);
    peek(4, 32'hA5A5_A5A5, "R8");
    req = "R9"; wr(0, 32'h0050_0050);
    wr(0, 32'h0070_0070);
    peek(4, 32'h0080_0080, "R9");

    // R10: writes during busy are ignored, mode stays status
    req = "R10"; wr(5, 32'h0040_0040);
    wr(5, 32'h0000_0000);
    wr(5, 32'h00FF_00FF);
    wr(5, 32'h0090_0090);
    count_busy(PC - 2, "R10");
    peek(5, 32'h0080_0080, "R10");
    req = "R10"; wr(0, 32'h00FF_00FF);
    peek(5, 32'h0000_0000, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule